// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block sits beside the access arbiter of an SDRAM controller and owns the periodic auto-refresh duty and the clock-enable based low-power states of one SDRAM device. A free-running interval counter adds one owed refresh per interval. Whenever a refresh is owed, or a power manager asks for self-refresh or power-down, the block raises a request toward the arbiter. Once the arbiter acknowledges, the block holds `busy` high and drives the command pins and CKE itself until the required spacing has elapsed.

Owed refreshes may be postponed by the arbiter and are then issued as a back-to-back burst. If a bank is still open when a low-power state is requested, a precharge-all is issued first. Leaving self-refresh always ends in one auto-refresh before traffic resumes. Power-down is abandoned on its own as soon as a refresh falls due, because the device does not refresh itself in that state. Priority among pending work is self-refresh first, then owed refreshes, then power-down.

Command encodings on (cs_n, ras_n, cas_n, we_n) are: auto-refresh 0001 with CKE high, self-refresh entry 0001 with CKE low, precharge-all 0010 with `a10` high. All other cycles deselect the device (cs_n high).

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset CKE is high, cs_n is high, `busy`, `rfsh_req`, `pd_active` and `sr_active` are low. An acknowledge while no request is raised leaves `busy` low.
- R2: `rfsh_req` rises once T_REFI cycles have produced an owed refresh. The cycle after an acknowledge is sampled, an auto-refresh command (cs_n, ras_n, cas_n low, we_n high, CKE high) is driven and `busy` is high.
- R3: Consecutive auto-refresh commands are exactly T_RC cycles apart, and `busy` falls exactly T_RC cycles after the last auto-refresh of a burst.
- R4: Owed refreshes accumulate while the arbiter withholds its acknowledge, up to MAX_PEND. One acknowledge then issues all of them as a burst.
- R5: With `sr_req` high and no bank open, the cycle after the acknowledge carries the self-refresh command (cs_n, ras_n, cas_n low, we_n high, CKE low). `sr_active` is high from the next cycle, and while it lasts CKE stays low and no command is driven, even across refresh intervals.
- R6: When `sr_req` drops, CKE is high in the next cycle with no command. An auto-refresh follows exactly T_RC cycles after that cycle, and `busy` falls T_RC cycles after the auto-refresh.
- R7: If `banks_open` is high when a low-power request is acknowledged, the next cycle carries precharge-all (cs_n, ras_n, we_n low, cas_n high, `a10` high). Low-power entry (CKE low) follows exactly T_RP cycles later.
- R8: With no bank open and no refresh owed, an acknowledged `pd_req` drives CKE low with `pd_active` high in the next cycle and issues no precharge. Dropping `pd_req` returns CKE high one cycle later, and `busy` falls the cycle after that.
- R9: If a refresh falls due during power-down, the block leaves power-down by itself: one cycle with CKE high and no command, then an auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rfsh_ack | input | 1 | Arbiter hands the command bus over from the next cycle |
| banks_open | input | 1 | At least one bank is currently active |
| pd_req | input | 1 | Power manager asks for power-down (level) |
| sr_req | input | 1 | Power manager asks for self-refresh (level) |
| rfsh_req | output | 1 | Sequencer needs the command bus |
| busy | output | 1 | Sequencer owns the bus; arbiter must not issue commands |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, high selects all banks on precharge |
| pd_active | output | 1 | Device is in power-down |
| sr_active | output | 1 | Device is in self-refresh |

## Verification
The bench measures the exact cycle distance between auto-refresh commands in bursts of one, three and a saturated four. An off-by-one counter would place commands one cycle early or late, and a missing cap would emit extra refreshes. It holds self-refresh over several refresh intervals and checks the exit, where a design that kept counting intervals would issue stray refreshes, and one that omitted the trailing refresh or its spacing would release the bus too soon. Power-down is entered both with open and with closed banks, and is also left waiting until a refresh falls due. A design that skipped the precharge, mistimed it against T_RP, or stayed asleep past the interval is caught at the command pins.

// File: rtl/rfsh_pkg.sv
// Shared types for the refresh and low-power sequencer.
// Assumes: pin encodings follow the usual SDRAM command truth table.
package rfsh_pkg;

    typedef enum logic [3:0] {
        S_IDLE,   // arbiter owns the bus
        S_REF,    // auto-refresh command cycle
        S_WRC,    // row-cycle spacing after refresh or self-refresh exit
        S_PRE,    // precharge-all command cycle
        S_WRP,    // precharge recovery
        S_SRE,    // self-refresh entry command cycle
        S_SR,     // inside self-refresh
        S_SRX,    // self-refresh exit, CKE back high
        S_PD,     // inside power-down
        S_PDX     // power-down exit cycle
    } seq_state_t;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } pin_cmd_t;

    localparam pin_cmd_t PINS_DESEL  = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam pin_cmd_t PINS_SLEEP  = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam pin_cmd_t PINS_AREF   = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    localparam pin_cmd_t PINS_SREF   = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    localparam pin_cmd_t PINS_PREALL = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};

endpackage

// File: rtl/rfsh_interval_ctr.sv
// Refresh interval counter with a saturating count of owed refreshes.
// A tick is produced every T_REFI cycles; each tick owes one refresh,
// each issued refresh pays one back. hold clears both the interval and
// the debt (the device refreshes itself); seed sets the debt to one.
// Assumes: T_REFI >= 2, MAX_PEND >= 1.
module rfsh_interval_ctr #(
    parameter int T_REFI   = 1560,
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic seed,
    input  logic dec,
    output logic owed
);
    localparam int REFI_W = (T_REFI > 2) ? $clog2(T_REFI) : 1;
    localparam int PEND_W = $clog2(MAX_PEND + 1);

    logic [REFI_W-1:0] ivl_q;
    logic [PEND_W-1:0] pend_q;
    logic              tick;

    assign tick = (ivl_q == REFI_W'(T_REFI - 1));
    assign owed = (pend_q != '0);

    // Advance the interval counter, restarting it while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || seed) ivl_q <= '0;
        else if (tick)              ivl_q <= '0;
        else                        ivl_q <= ivl_q + 1'b1;
    end

    // Track owed refreshes: add on tick, remove on issue, cap at MAX_PEND.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pend_q <= '0;
        end else if (seed) begin
            pend_q <= PEND_W'(1);
        end else begin
            unique case ({tick, dec})
                2'b10:   if (pend_q != PEND_W'(MAX_PEND)) pend_q <= pend_q + 1'b1;
                2'b01:   if (pend_q != '0)                pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    // R4
    pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == PEND_W'(MAX_PEND) && tick && !dec) |=> (pend_q == PEND_W'(MAX_PEND)));
endmodule

// File: rtl/rfsh_gap_timer.sv
// Down-counter that enforces a minimum gap after a command.
// done is high when at most one cycle of the loaded gap remains, so a
// state that leaves on done starts its successor exactly on time.
// Assumes: loaded values are at least 1.
module rfsh_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = (cnt_q <= W'(1));

    // Load a new gap or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/rfsh_pin_decode.sv
// Maps the sequencer state onto the SDRAM command pins and CKE.
// Assumes: every non-command cycle deselects the device.
module rfsh_pin_decode
    import rfsh_pkg::*;
(
    input  seq_state_t st,
    output pin_cmd_t   pins
);
    // Select the pin pattern for the current state.
    always_comb begin
        unique case (st)
            S_REF:       pins = PINS_AREF;
            S_PRE:       pins = PINS_PREALL;
            S_SRE:       pins = PINS_SREF;
            S_SR, S_PD:  pins = PINS_SLEEP;
            default:     pins = PINS_DESEL;
        endcase
    end
endmodule

// File: rtl/sdram_refresh_seq.sv
// Refresh and low-power sequencer for one SDRAM device.
// Requests the command bus from the arbiter, then issues auto-refresh
// bursts, precharge-all, self-refresh and power-down entry/exit while
// holding busy until the row-cycle or precharge spacing is met.
// Assumes: T_RC >= 2, T_RP >= 2; banks_open reflects the arbiter's view.
module sdram_refresh_seq
    import rfsh_pkg::*;
#(
    parameter int T_RC     = 8,
    parameter int T_RP     = 3,
    parameter int T_REFI   = 1560,
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_ack,
    input  logic banks_open,
    input  logic pd_req,
    input  logic sr_req,
    output logic rfsh_req,
    output logic busy,
    output logic cke,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic a10,
    output logic pd_active,
    output logic sr_active
);
    localparam int T_MAX = (T_RC > T_RP) ? T_RC : T_RP;
    localparam int TMR_W = $clog2(T_MAX + 1);

    seq_state_t       st_q, st_d;
    logic             to_sr_q;
    logic             owed;
    logic             tmr_load, tmr_done;
    logic [TMR_W-1:0] tmr_val;
    pin_cmd_t         pins;

    rfsh_interval_ctr #(.T_REFI(T_REFI), .MAX_PEND(MAX_PEND)) u_ivl (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (st_q == S_SRE || st_q == S_SR),
        .seed (st_q == S_SRX),
        .dec  (st_q == S_REF),
        .owed (owed)
    );

    rfsh_gap_timer #(.W(TMR_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    rfsh_pin_decode u_pins (
        .st  (st_q),
        .pins(pins)
    );

    assign rfsh_req  = (st_q == S_IDLE) && (owed || sr_req || pd_req);
    assign busy      = (st_q != S_IDLE);
    assign pd_active = (st_q == S_PD);
    assign sr_active = (st_q == S_SR);
    assign cke   = pins.cke;
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign a10   = pins.a10;

    // Choose the next state and arm the gap timer on command cycles.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(T_RC - 1);
        unique case (st_q)
            S_IDLE: if (rfsh_req && rfsh_ack) begin
                if (sr_req)          st_d = banks_open ? S_PRE : S_SRE;
                else if (owed)       st_d = S_REF;
                else                 st_d = banks_open ? S_PRE : S_PD;
            end
            S_REF: begin
                tmr_load = 1'b1;
                st_d     = S_WRC;
            end
            S_WRC: if (tmr_done)     st_d = owed ? S_REF : S_IDLE;
            S_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_RP - 1);
                st_d     = S_WRP;
            end
            S_WRP: if (tmr_done)     st_d = to_sr_q ? S_SRE : S_PD;
            S_SRE:                   st_d = S_SR;
            S_SR:  if (!sr_req)      st_d = S_SRX;
            S_SRX: begin
                tmr_load = 1'b1;
                st_d     = S_WRC;
            end
            S_PD:  if (!pd_req || owed) st_d = S_PDX;
            S_PDX:                   st_d = owed ? S_REF : S_IDLE;
            default:                 st_d = S_IDLE;
        endcase
    end

    // Register the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Remember which low-power state follows a precharge-all.
    always_ff @(posedge clk) begin
        if (!rst_n)               to_sr_q <= 1'b0;
        else if (st_q == S_IDLE)  to_sr_q <= sr_req;
    end

    // ---------------- checks next to the logic they guard ----------------
    logic             ref_cmd;
    logic             ref_seen_q;
    logic [TMR_W-1:0] since_ref_q;

    assign ref_cmd = cke && !cs_n && !ras_n && !cas_n && we_n;

    // Measure cycles since the last auto-refresh on the pins, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_seen_q  <= 1'b0;
            since_ref_q <= '0;
        end else if (ref_cmd) begin
            ref_seen_q  <= 1'b1;
            since_ref_q <= TMR_W'(1);
        end else if (since_ref_q < TMR_W'(T_RC)) begin
            since_ref_q <= since_ref_q + 1'b1;
        end
    end

    // R3
    ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cmd && ref_seen_q) |-> (since_ref_q >= TMR_W'(T_RC)));

    // R3
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ref_seen_q) |-> (since_ref_q >= TMR_W'(T_RC)));

    // R7
    prech_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_req && rfsh_ack && sr_req && banks_open && !busy)
        |=> (!cs_n && !ras_n && cas_n && !we_n && a10));

    // R6
    sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sr_active) && !sr_active) |-> (cke && cs_n));

    // R9
    pd_forced_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && owed) |=> (!pd_active && cke));
endmodule

// File: tb/sim_sdram_refresh_seq.sv
// Directed bench for sdram_refresh_seq: one task per scenario.
module sim_sdram_refresh_seq;
    localparam int T_RC     = 4;
    localparam int T_RP     = 3;
    localparam int T_REFI   = 40;
    localparam int MAX_PEND = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rfsh_ack = 1'b0, banks_open = 1'b0, pd_req = 1'b0, sr_req = 1'b0;
    logic rfsh_req, busy, cke, cs_n, ras_n, cas_n, we_n, a10, pd_active, sr_active;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_ref = -1;

    always #4 clk = ~clk;   // 125 MHz

    sdram_refresh_seq #(.T_RC(T_RC), .T_RP(T_RP), .T_REFI(T_REFI), .MAX_PEND(MAX_PEND)) u0 (
        .clk(clk), .rst_n(rst_n), .rfsh_ack(rfsh_ack), .banks_open(banks_open),
        .pd_req(pd_req), .sr_req(sr_req), .rfsh_req(rfsh_req), .busy(busy),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .a10(a10), .pd_active(pd_active), .sr_active(sr_active)
    );

    function automatic logic is_ref();
        return cke && !cs_n && !ras_n && !cas_n && we_n;
    endfunction
    function automatic logic is_sre();
        return !cke && !cs_n && !ras_n && !cas_n && we_n;
    endfunction
    function automatic logic is_pre();
        return !cs_n && !ras_n && cas_n && !we_n && a10;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        rfsh_ack = 1'b1;
        step();
        rfsh_ack = 1'b0;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: no two auto-refreshes closer than T_RC (R3).
    always @(negedge clk) begin
        if (rst_n && is_ref()) begin
            if (last_ref >= 0) chk("R3 min spacing", (cyc - last_ref) >= T_RC, 1);
            last_ref = cyc;
        end
    end

    task automatic wait_req_rise();
        int n = 0;
        while (rfsh_req && n < 2000) begin step(); n++; end
        while (!rfsh_req && n < 2000) begin step(); n++; end
        chk("R2 request raised", rfsh_req, 1);
    endtask

    // Retire one refresh so the next interval is a full T_REFI away.
    task automatic sync_to_tick();
        wait_req_rise();
        pulse_ack();
        repeat (T_RC + 1) step();
    endtask

    task automatic t_reset();
        chk("R1 cke", cke, 1);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 busy", busy, 0);
        chk("R1 rfsh_req", rfsh_req, 0);
        chk("R1 low-power flags", {pd_active, sr_active}, 0);
        pulse_ack();
        chk("R1 stray ack ignored", busy, 0);
    endtask

    // Postponed refreshes: extra_ticks intervals withheld, exp refreshes due.
    task automatic t_burst(input int extra_ticks, input int exp, input string tag);
        int good = 0;
        int bad = 0;
        wait_req_rise();
        repeat (extra_ticks * T_REFI + 5) step();
        pulse_ack();
        chk({tag, " busy after ack"}, busy, 1);
        for (int k = 0; k < exp * T_RC; k++) begin
            if (k % T_RC == 0) begin if (is_ref()) good++; else bad++; end
            else if (!cs_n) bad++;
            if (!busy) bad++;
            step();
        end
        chk({tag, " refreshes on exact T_RC grid"}, good, exp);
        chk({tag, " misplaced commands"}, bad, 0);
        chk({tag, " busy released T_RC after last"}, busy, 0);
        chk({tag, " no extra refresh"}, is_ref(), 0);
    endtask

    task automatic t_pd_closed();
        sync_to_tick();
        banks_open = 1'b0;
        pd_req = 1'b1;
        step();
        pulse_ack();
        chk("R8 cke low after ack", cke, 0);
        chk("R8 pd_active", pd_active, 1);
        chk("R8 no precharge", cs_n, 1);
        repeat (3) step();
        pd_req = 1'b0;
        step();
        chk("R8 cke high one cycle after release", cke, 1);
        chk("R8 pd_active dropped", pd_active, 0);
        step();
        chk("R8 busy released", busy, 0);
    endtask

    task automatic t_pd_forced();
        int found = 0;
        logic prev_cke = 1'b0;
        logic prev_pd = 1'b1;
        sync_to_tick();
        pd_req = 1'b1;
        step();
        pulse_ack();
        chk("R9 entered power-down", pd_active, 1);
        for (int k = 0; k < T_REFI + 5 && found == 0; k++) begin
            prev_cke = cke;
            prev_pd = pd_active;
            step();
            if (is_ref()) found = 1;
        end
        chk("R9 refresh issued from power-down", found, 1);
        chk("R9 exit cycle cke high", prev_cke, 1);
        chk("R9 exit cycle left power-down", prev_pd, 0);
        pd_req = 1'b0;
        repeat (T_RC) step();
        chk("R9 busy released", busy, 0);
    endtask

    task automatic t_pd_open();
        sync_to_tick();
        banks_open = 1'b1;
        pd_req = 1'b1;
        step();
        pulse_ack();
        chk("R7 precharge-all first", is_pre(), 1);
        repeat (T_RP - 1) step();
        chk("R7 cke still high before T_RP", cke, 1);
        step();
        chk("R7 cke low at T_RP", cke, 0);
        chk("R7 in power-down", pd_active, 1);
        banks_open = 1'b0;
        pd_req = 1'b0;
        repeat (2) step();
        chk("R7 back to idle", busy, 0);
    endtask

    task automatic t_sr(input logic open, input string tag);
        int stray = 0;
        sync_to_tick();
        banks_open = open;
        sr_req = 1'b1;
        step();
        pulse_ack();
        if (open) begin
            chk({tag, " R7 precharge-all first"}, is_pre(), 1);
            repeat (T_RP) step();
        end
        chk({tag, " R5 self-refresh command"}, is_sre(), 1);
        banks_open = 1'b0;
        step();
        chk({tag, " R5 sr_active"}, sr_active, 1);
        repeat (2 * T_REFI + 10) begin
            if (cke || !cs_n || !sr_active) stray++;
            step();
        end
        chk({tag, " R5 quiet in self-refresh"}, stray, 0);
        sr_req = 1'b0;
        step();
        chk({tag, " R6 cke high on exit"}, cke, 1);
        chk({tag, " R6 no command on exit"}, cs_n, 1);
        stray = 0;
        repeat (T_RC - 1) begin step(); if (!cs_n) stray++; end
        chk({tag, " R6 no command inside T_RC"}, stray, 0);
        step();
        chk({tag, " R6 refresh at T_RC"}, is_ref(), 1);
        repeat (T_RC - 1) step();
        chk({tag, " R6 busy held"}, busy, 1);
        step();
        chk({tag, " R6 busy released"}, busy, 0);
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_burst(0, 1, "R2 single");
        t_burst(2, 3, "R4 burst of three");
        t_burst(5, MAX_PEND, "R4 saturated");
        t_pd_closed();
        t_pd_open();
        t_pd_forced();
        t_sr(1'b0, "closed");
        t_sr(1'b1, "open");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule